// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out pieces of one contiguous address region. Every piece is an aligned power-of-two block. The smallest block is `2^MIN_LOG2` bytes and the whole region is `2^(MIN_LOG2+NUM_ORD-1)` bytes. A block's order is the base-2 logarithm of its size divided by the minimum size, so order 0 is the smallest block and order `NUM_ORD-1` is the whole region.

A requester presents a byte count on the allocation port. The block rounds that count up to a block order and answers one cycle later with either a base address or a failure indication. The release port takes a base address and an order. The block frees that block and then folds it together with its free same-sized partner, again and again, as high as the free space allows.

Free and owned blocks are kept as two bitmaps with one bit for every block of every order. Each request is finished in the cycle it is accepted. The allocation port and the release port each have a valid/ready handshake. When both are valid in the same cycle, the allocation is served first.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole region is one free block. Both ready outputs are high once the reset has been released, and neither done output is raised until a request is accepted.
- R2: A request size of 0 up to `2^MIN_LOG2` bytes maps to order 0. A larger size maps to the smallest order k with `2^(MIN_LOG2+k)` at or above the size. `alloc_order` reports the chosen order.
- R3: An allocation uses a free block of the smallest order at or above the requested order. Among free blocks of that order it uses the one at the lowest address.
- R4: When the chosen block is larger than needed, it is halved down to the requested order. Each upper half becomes a free block of its own order, and the requester gets the lowest part. With a 1 MiB region and a 64 KiB minimum, requests of 70K, 35K and 80K bytes get 0, 128K and 256K. Releasing the first block and then asking for 60K gets 192K.
- R5: A released block merges only with its partner of equal size, whose base is its own base XOR its size. Merging repeats upward, so releasing every owned block gives back one free block covering the whole region.
- R6: A request larger than the region, or one for which no free block is large enough, returns `alloc_fail` high. A failed request changes no block state.
- R7: A release is rejected with `rel_err` high, and has no effect, in any of these cases: the order is `NUM_ORD` or above, the address is not aligned to the block size, or the block at that address and order is not currently owned.
- R8: An accepted request raises its done output exactly one cycle after acceptance. `rel_ready` is low in any cycle where `alloc_valid` is high.
- R9: The address returned by a successful allocation is aligned to the size of its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Allocation request can be taken |
| alloc_size | input | MIN_LOG2+NUM_ORD | Requested byte count |
| alloc_done | output | 1 | One-cycle pulse: allocation answer valid |
| alloc_fail | output | 1 | No block could be given (held with the answer) |
| alloc_addr | output | MIN_LOG2+NUM_ORD-1 | Base byte address of the granted block |
| alloc_order | output | clog2(NUM_ORD) | Order the request was rounded to |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release request can be taken |
| rel_addr | input | MIN_LOG2+NUM_ORD-1 | Base byte address of the block to free |
| rel_order | input | clog2(NUM_ORD) | Order of the block to free |
| rel_done | output | 1 | One-cycle pulse: release answer valid |
| rel_err | output | 1 | Release was rejected (held with the answer) |

## Verification
The bench aims at these corner cases:

- **Sizes exactly at a power of two and one byte above it.** An off-by-one in the rounding would hand out twice the needed block, or a block too small to hold the request.
- **Releases that must cascade through every order back to the full region.** A merge that stops early, or that pairs a block with the wrong neighbour, would make a later whole-region request fail.
- **Requests made while the region is full, or that are larger than the region.** A fail path that still updates state would corrupt the bitmaps, and that would show up in later addresses.
- **Releases with a wrong order, a misaligned address, or a block that was already freed.** A design that accepted any of these would create phantom free blocks and go on to hand out overlapping addresses.

A long pseudo-random mix of requests and releases is compared against an occupancy model. That model treats every maximal all-free aligned block as free.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  // Flat index of the first node of order k in a map with n orders.
  // Order 0 has 2^(n-1) nodes and is stored first; the top order has one node and is stored last.
  function automatic int ord_off(input int k, input int n);
    return (1 << n) - (1 << (n - k));
  endfunction
endpackage

// File: rtl/buddy_round.sv
module buddy_round #(
  parameter int MIN_LOG2 = 16,
  parameter int NUM_ORD  = 5,
  parameter int SZ_W     = MIN_LOG2 + NUM_ORD,
  parameter int ORD_W    = $clog2(NUM_ORD)
) (
  input  logic [SZ_W-1:0]  size,
  output logic [ORD_W-1:0] ord,
  output logic             too_big
);
  localparam int TOP_LOG2 = MIN_LOG2 + NUM_ORD - 1;

  always_comb begin
    ord     = '0;
    too_big = size > (SZ_W'(1) << TOP_LOG2);
    // Walk from the top order down; the last order that still covers the size wins.
    for (int k = NUM_ORD - 1; k >= 0; k--) begin
      if (size <= (SZ_W'(1) << (MIN_LOG2 + k))) ord = ORD_W'(k);
    end
  end
endmodule

// File: rtl/buddy_pick.sv
module buddy_pick
  import buddy_pkg::*;
#(
  parameter int NUM_ORD = 5,
  parameter int NODES   = (1 << NUM_ORD) - 1,
  parameter int ORD_W   = $clog2(NUM_ORD),
  parameter int IDX_W   = NUM_ORD - 1
) (
  input  logic [NODES-1:0] free_map,
  input  logic [ORD_W-1:0] want,
  output logic             found,
  output logic [ORD_W-1:0] hit_ord,
  output logic [IDX_W-1:0] hit_idx
);
  always_comb begin
    found   = 1'b0;
    hit_ord = '0;
    hit_idx = '0;
    // Both loops run downward, so the final hit is the smallest order and, within it, the lowest index.
    for (int k = NUM_ORD - 1; k >= 0; k--) begin
      if (k >= int'(want)) begin
        for (int i = (1 << (NUM_ORD - 1 - k)) - 1; i >= 0; i--) begin
          if (free_map[ord_off(k, NUM_ORD) + i]) begin
            found   = 1'b1;
            hit_ord = ORD_W'(k);
            hit_idx = IDX_W'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int MIN_LOG2 = 16,
  parameter int NUM_ORD  = 5,
  localparam int ADDR_W  = MIN_LOG2 + NUM_ORD - 1,
  localparam int SZ_W    = ADDR_W + 1,
  localparam int ORD_W   = $clog2(NUM_ORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [SZ_W-1:0]   alloc_size,
  output logic              alloc_done,
  output logic              alloc_fail,
  output logic [ADDR_W-1:0] alloc_addr,
  output logic [ORD_W-1:0]  alloc_order,
  input  logic              rel_valid,
  output logic              rel_ready,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic [ORD_W-1:0]  rel_order,
  output logic              rel_done,
  output logic              rel_err
);
  localparam int NODES = (1 << NUM_ORD) - 1;
  localparam int IDX_W = NUM_ORD - 1;
  localparam int AW1   = ADDR_W + 1;

  // Reset synchroniser: the reset is asserted asynchronously and released on a clock edge.
  logic rs_a, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a    <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_a    <= 1'b1;
      rst_n_s <= rs_a;
    end
  end

  logic [NODES-1:0]  free_q, free_d, used_q, used_d;
  logic              run_q, adone_q, fail_q, rdone_q, err_q;
  logic              fail_d, err_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ORD_W-1:0]  ord_q;

  logic [ORD_W-1:0] want, hit_ord;
  logic [IDX_W-1:0] hit_idx;
  logic             too_big, found;

  buddy_round #(.MIN_LOG2(MIN_LOG2), .NUM_ORD(NUM_ORD), .SZ_W(SZ_W), .ORD_W(ORD_W)) u_round (
    .size(alloc_size), .ord(want), .too_big(too_big));

  buddy_pick #(.NUM_ORD(NUM_ORD), .NODES(NODES), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_pick (
    .free_map(free_q), .want(want), .found(found), .hit_ord(hit_ord), .hit_idx(hit_idx));

  logic acc_alloc, acc_rel;
  assign alloc_ready = run_q;
  assign rel_ready   = run_q & ~alloc_valid;
  assign acc_alloc   = alloc_valid & alloc_ready;
  assign acc_rel     = rel_valid & rel_ready;

  // Checking a release request
  int             ro, rcur, cur;
  logic [AW1-1:0] amask;
  logic           rel_ok, merging;

  always_comb begin
    ro     = (int'(rel_order) < NUM_ORD) ? int'(rel_order) : 0;
    amask  = (AW1'(1) << (MIN_LOG2 + ro)) - AW1'(1);
    rcur   = int'(rel_addr >> (MIN_LOG2 + ro));
    rel_ok = (int'(rel_order) < NUM_ORD) && (({1'b0, rel_addr} & amask) == '0)
             && used_q[ord_off(ro, NUM_ORD) + rcur];
  end

  // Next-state logic
  always_comb begin
    free_d  = free_q;
    used_d  = used_q;
    fail_d  = 1'b0;
    err_d   = 1'b0;
    addr_d  = '0;
    cur     = 0;
    merging = 1'b0;
    if (acc_alloc) begin
      if (too_big || !found) begin
        fail_d = 1'b1;
      end else begin
        free_d[ord_off(int'(hit_ord), NUM_ORD) + int'(hit_idx)] = 1'b0;
        cur = int'(hit_idx);
        // Split downward: keep the lower half each time and free the upper half.
        for (int j = NUM_ORD - 2; j >= 0; j--) begin
          if (j < int'(hit_ord) && j >= int'(want)) begin
            cur = cur * 2;
            free_d[ord_off(j, NUM_ORD) + cur + 1] = 1'b1;
          end
        end
        used_d[ord_off(int'(want), NUM_ORD) + cur] = 1'b1;
        addr_d = ADDR_W'(cur) << (MIN_LOG2 + int'(want));
      end
    end else if (acc_rel) begin
      if (!rel_ok) begin
        err_d = 1'b1;
      end else begin
        used_d[ord_off(ro, NUM_ORD) + rcur] = 1'b0;
        cur     = rcur;
        merging = 1'b1;
        // Merge upward while the same-size partner is free.
        for (int j = 0; j < NUM_ORD; j++) begin
          if (merging && j >= ro) begin
            if (j < NUM_ORD - 1 && free_d[ord_off(j, NUM_ORD) + (cur ^ 1)]) begin
              free_d[ord_off(j, NUM_ORD) + (cur ^ 1)] = 1'b0;
              cur = cur / 2;
            end else begin
              free_d[ord_off(j, NUM_ORD) + cur] = 1'b1;
              merging = 1'b0;
            end
          end
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      free_q  <= NODES'(1) << (NODES - 1);
      used_q  <= '0;
      run_q   <= 1'b0;
      adone_q <= 1'b0;
      rdone_q <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      ord_q   <= '0;
    end else begin
      run_q   <= 1'b1;
      adone_q <= acc_alloc;
      rdone_q <= acc_rel;
      if (acc_alloc || acc_rel) begin
        free_q <= free_d;
        used_q <= used_d;
      end
      if (acc_alloc) begin
        fail_q <= fail_d;
        addr_q <= addr_d;
        ord_q  <= want;
      end
      if (acc_rel) err_q <= err_d;
    end
  end

  assign alloc_done  = adone_q;
  assign alloc_fail  = fail_q;
  assign alloc_addr  = addr_q;
  assign alloc_order = ord_q;
  assign rel_done    = rdone_q;
  assign rel_err     = err_q;
endmodule

// File: rtl/buddy_chk.sv
module buddy_chk #(
  parameter int MIN_LOG2 = 16,
  parameter int NUM_ORD  = 5,
  localparam int ADDR_W  = MIN_LOG2 + NUM_ORD - 1,
  localparam int SZ_W    = ADDR_W + 1,
  localparam int ORD_W   = $clog2(NUM_ORD)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [SZ_W-1:0]   alloc_size,
  input logic              alloc_done,
  input logic              alloc_fail,
  input logic [ADDR_W-1:0] alloc_addr,
  input logic [ORD_W-1:0]  alloc_order,
  input logic              rel_ready
);
  localparam logic [SZ_W-1:0] REGION = SZ_W'(1) << ADDR_W;

  logic [SZ_W-1:0] blk_bytes;
  logic            acc;
  assign blk_bytes = SZ_W'(1) << (MIN_LOG2 + int'(alloc_order));
  assign acc       = alloc_valid && alloc_ready;

  a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> alloc_done);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !alloc_done);
  a_r8_release_yields: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !rel_ready);
  a_r2_block_covers: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (alloc_fail || blk_bytes >= $past(alloc_size)));
  a_r6_oversize_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && alloc_size > REGION) |=> alloc_fail);
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && !alloc_fail) |-> (({1'b0, alloc_addr} & (blk_bytes - SZ_W'(1))) == '0));
endmodule

bind buddy_alloc buddy_chk #(.MIN_LOG2(MIN_LOG2), .NUM_ORD(NUM_ORD)) u_buddy_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_size(alloc_size), .alloc_done(alloc_done), .alloc_fail(alloc_fail),
  .alloc_addr(alloc_addr), .alloc_order(alloc_order), .rel_ready(rel_ready));

// File: tb/test_buddy_alloc.sv
`timescale 1ns/1ps
module test_buddy_alloc;
  localparam int MINL  = 16;
  localparam int NORD  = 5;
  localparam int AW    = MINL + NORD - 1;
  localparam int SW    = AW + 1;
  localparam int OW    = $clog2(NORD);
  localparam int NU    = 1 << (NORD - 1);
  localparam longint MINB = 64'd1 << MINL;
  localparam longint KB   = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, rel_valid = 1'b0;
  logic [SW-1:0] alloc_size = '0;
  logic [AW-1:0] rel_addr = '0;
  logic [OW-1:0] rel_order = '0;
  logic alloc_ready, alloc_done, alloc_fail, rel_ready, rel_done, rel_err;
  logic [AW-1:0] alloc_addr;
  logic [OW-1:0] alloc_order;

  buddy_alloc #(.MIN_LOG2(MINL), .NUM_ORD(NORD)) i_buddy_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_size(alloc_size), .alloc_done(alloc_done), .alloc_fail(alloc_fail),
    .alloc_addr(alloc_addr), .alloc_order(alloc_order), .rel_valid(rel_valid),
    .rel_ready(rel_ready), .rel_addr(rel_addr), .rel_order(rel_order),
    .rel_done(rel_done), .rel_err(rel_err));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit unit_used [NU];
  int blk_base [NU];
  int blk_ord  [NU];
  bit blk_live [NU];
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic bit all_free(input int k, input int i);
    for (int u = i << k; u < (i + 1) << k; u++) if (unit_used[u]) return 1'b0;
    return 1'b1;
  endfunction

  // Expected free blocks: maximal aligned blocks whose units are all free
  function automatic bit max_free(input int k, input int i);
    if (!all_free(k, i)) return 1'b0;
    if (k == NORD - 1) return 1'b1;
    return !all_free(k + 1, i >> 1);
  endfunction

  task automatic do_alloc(input longint sz_in, input string rq, output longint got);
    longint sz;
    int r, base_u;
    bit f;
    sz = sz_in & ((64'd1 << SW) - 1);
    r = 0;
    while (r < NORD && (MINB << r) < sz) r++;
    f = 1'b1;
    base_u = 0;
    for (int k = r; k < NORD; k++)
      for (int i = 0; i < (NU >> k); i++)
        if (f && max_free(k, i)) begin
          f = 1'b0;
          base_u = i << k;
        end
    @(negedge clk);
    alloc_size = SW'(sz);
    alloc_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0;
    chk(alloc_done == 1'b1, "R8 alloc done", alloc_done, 1);
    chk(alloc_fail == f, {rq, " fail flag"}, alloc_fail, f);
    got = -1;
    if (!f) begin
      chk(alloc_addr == AW'(longint'(base_u) * MINB), {rq, " address"}, alloc_addr, longint'(base_u) * MINB);
      chk(alloc_order == OW'(r), "R2 order", alloc_order, r);
      got = longint'(base_u) * MINB;
      for (int u = base_u; u < base_u + (1 << r); u++) unit_used[u] = 1'b1;
      for (int s = 0; s < NU; s++)
        if (!blk_live[s]) begin
          blk_live[s] = 1'b1;
          blk_base[s] = base_u;
          blk_ord[s] = r;
          break;
        end
    end
  endtask

  task automatic do_free(input longint addr, input int ord, input string rq);
    int hit;
    hit = -1;
    if (addr % MINB == 0)
      for (int s = 0; s < NU; s++)
        if (blk_live[s] && longint'(blk_base[s]) * MINB == addr && blk_ord[s] == ord) hit = s;
    @(negedge clk);
    rel_addr = AW'(addr);
    rel_order = OW'(ord);
    rel_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    chk(rel_done == 1'b1, "R8 release done", rel_done, 1);
    chk(rel_err == (hit < 0), {rq, " release error flag"}, rel_err, hit < 0);
    if (hit >= 0) begin
      blk_live[hit] = 1'b0;
      for (int u = blk_base[hit]; u < blk_base[hit] + (1 << ord); u++) unit_used[u] = 1'b0;
    end
  endtask

  task automatic free_all(input string rq);
    for (int s = 0; s < NU; s++)
      if (blk_live[s]) do_free(longint'(blk_base[s]) * MINB, blk_ord[s], rq);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  initial begin
    longint a, b, c, d, x;
    logic [31:0] lf;
    for (int u = 0; u < NU; u++) begin
      unit_used[u] = 1'b0;
      blk_live[u] = 1'b0;
      blk_base[u] = 0;
      blk_ord[u] = 0;
    end
    repeat (3) @(negedge clk);
    chk(alloc_ready == 1'b0, "R1 ready low in reset", alloc_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(alloc_ready == 1'b1 && rel_ready == 1'b1, "R1 ready after reset", {alloc_ready, rel_ready}, 3);
    chk(alloc_done == 1'b0 && rel_done == 1'b0, "R1 no done after reset", {alloc_done, rel_done}, 0);
    do_alloc(1024 * KB, "R1 whole region", x);
    free_all("R1");

    // R4: split sequence with 1 MiB region and 64 KiB minimum
    do_alloc(70 * KB, "R4", a);  chk(a == 0, "R4 70K", a, 0);
    do_alloc(35 * KB, "R4", b);  chk(b == 128 * KB, "R4 35K", b, 128 * KB);
    do_alloc(80 * KB, "R4", c);  chk(c == 256 * KB, "R4 80K", c, 256 * KB);
    do_free(a, 1, "R4");
    do_alloc(60 * KB, "R4", d);  chk(d == 192 * KB, "R4 60K", d, 192 * KB);
    do_free(b, 0, "R5");
    do_free(d, 0, "R5");
    do_free(c, 1, "R5");
    do_alloc(1024 * KB, "R5 full merge", x); chk(x == 0, "R5 full region back", x, 0);
    free_all("R5");

    // R2: rounding at and just above each power of two
    do_alloc(0, "R2 zero size", x); free_all("R2");
    do_alloc(1, "R2 one byte", x);  free_all("R2");
    for (int k = 0; k < NORD; k++) begin
      do_alloc(MINB << k, "R2 exact", x);           free_all("R2");
      do_alloc((MINB << k) + 1, "R2 plus one", x);  free_all("R2");
    end

    // R6 and R3: oversize request, full region, lowest address
    do_alloc(1024 * KB + 1, "R6 oversize", x);
    for (int i = 0; i < NU; i++) do_alloc(MINB, "R3 fill", x);
    do_alloc(1, "R6 full", x);
    do_free(5 * MINB, 0, "R6");
    do_alloc(1, "R6 state kept", x); chk(x == 5 * MINB, "R3 lowest hole", x, 5 * MINB);
    free_all("R5");
    do_alloc(1024 * KB, "R5 merge after fill", x);
    free_all("R5");

    // R7: rejected releases
    do_free(0, 0, "R7 empty");
    do_alloc(128 * KB, "R7", x);
    do_free(0, 0, "R7 wrong order");
    do_free(64 * KB, 1, "R7 misaligned");
    do_free(0, 7, "R7 order out of range");
    do_free(0, 1, "R7 good");
    do_free(0, 1, "R7 double");
    do_alloc(1024 * KB, "R7 state kept", x);
    free_all("R7");

    // R8: allocation wins when both ports are valid
    @(negedge clk);
    alloc_size = SW'(1);
    alloc_valid = 1'b1;
    rel_valid = 1'b1;
    rel_addr = AW'(512 * KB);
    rel_order = '0;
    #1 chk(rel_ready == 1'b0, "R8 release held back", rel_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk(alloc_done == 1'b1 && rel_done == 1'b0, "R8 alloc first", {alloc_done, rel_done}, 2);
    chk(alloc_addr == '0, "R8 alloc addr", alloc_addr, 0);
    unit_used[0] = 1'b1; blk_live[0] = 1'b1; blk_base[0] = 0; blk_ord[0] = 0;
    alloc_valid = 1'b0;
    #1 chk(rel_ready == 1'b1, "R8 release ready again", rel_ready, 1);
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    chk(rel_done == 1'b1 && rel_err == 1'b1, "R8 held release served", {rel_done, rel_err}, 3);
    free_all("R8");

    // R3: long pseudo-random mix against the occupancy model
    lf = 32'h1ACE5EED;
    for (int n = 0; n < 3000; n++) begin
      lf = (lf >> 1) ^ ({32{lf[0]}} & 32'hA3000001);
      if (lf[1:0] == 2'b00) begin
        int s;
        s = -1;
        for (int t = 0; t < NU; t++) if (s < 0 && blk_live[(t + int'(lf[7:4])) % NU]) s = (t + int'(lf[7:4])) % NU;
        if (s >= 0 && lf[8]) do_free(longint'(blk_base[s]) * MINB, blk_ord[s], "R5 random");
        else do_free(longint'(lf[19:16]) * MINB, int'(lf[22:20]), "R7 random");
      end else if (lf[1:0] == 2'b01) begin
        free_all("R5 random");
      end else begin
        do_alloc(longint'(lf[23:2]) >> lf[27:24], "R3 random", x);
      end
    end
    free_all("R5");
    do_alloc(1024 * KB, "R5 final merge", x);
    finish_up();
  end
endmodule